// File: doc/BRIEF.md
# Preload Hint Decoder and Address Generator

This block accepts one instruction word per cycle, together with the values already read for its base and index registers and the current carry flag. It recognises the register-offset form of the data-preload hint in either of two 32-bit encodings, chosen by a select input. For a recognised word it produces a preload strobe, the intended access kind (read or write) and the target address. The target address is the base plus or minus the shifted index. The memory system treats the strobe as advice only: nothing is loaded and no register is written.

Words that do not fit the selected layout are reported as undefined. Words that name reserved register combinations are reported as unpredictable. A variable-length word whose base field is all ones belongs to the literal-address variant and is reported with a redirect flag so that another decoder can handle it. In each of these three cases no preload strobe is produced. Every result appears one clock edge after the accepting cycle, and the address and intent outputs keep their last issued values between hints.

Top module: `pld_hint_unit`

## Requirements
- R1: With `enc_sel`=0, a word is well formed only if insn[31:24]=8'hF7, insn[21:20]=2'b01 and insn[4]=0. Any other word raises `undef_enc` and issues no hint. Bits insn[15:12] have no effect.
- R2: With `enc_sel`=0, insn[22]=1 gives a read hint (`hint_write`=0) and insn[22]=0 gives a write hint (`hint_write`=1).
- R3: With `enc_sel`=0, insn[23]=1 gives base plus offset and insn[23]=0 gives base minus offset. The base comes from `base_val`, and all arithmetic is modulo 2^XLEN.
- R4: With `enc_sel`=0, the offset is `index_val` shifted according to type insn[6:5] and amount insn[11:7]. 00 is a left shift by the amount. 01 is a logical right shift and 10 is an arithmetic right shift, each by 32 when the amount is 0. 11 is a rotate right by the amount, or, when the amount is 0, a one-bit right shift with `carry_in` entering the top bit.
- R5: With `enc_sel`=1, a word is well formed only if insn[31:22]=10'b1111100000 and insn[20]=1. When insn[19:16] is not 4'hF, insn[15:12]=4'hF and insn[11:6]=0 are also required. Any other word raises `undef_enc` and issues no hint.
- R6: With `enc_sel`=1, insn[21]=1 gives a write hint and insn[21]=0 gives a read hint.
- R7: With `enc_sel`=1, the address is always `base_val` plus `index_val` shifted left by insn[5:4] (0 to 3).
- R8: With `enc_sel`=1, a word with a well-formed first half and insn[19:16]=4'hF raises `literal_redirect`. No hint is issued and `unpred_flag` stays low, whatever the lower halfword holds.
- R9: An index field insn[3:0]=4'hF raises `unpred_flag` in both encodings. With `enc_sel`=0, a base field insn[19:16]=4'hF together with write intent also raises it. No hint is issued in either case.
- R10: Each result strobe is high for exactly the one cycle after a cycle with `in_valid`=1. With `in_valid`=0, all strobes are low in the following cycle.
- R11: At most one of `hint_valid`, `undef_enc`, `literal_redirect` and `unpred_flag` is high in any cycle. The priority order is undefined first, then redirect, then unpredictable.
- R12: While `rst_n` is low, every output is zero. Inputs are accepted from the third rising edge after `rst_n` goes high.
- R13: `hint_addr` and `hint_write` change only together with `hint_valid`. Otherwise they hold the last issued values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands present this cycle |
| enc_sel | input | 1 | 0 selects the fixed-width layout, 1 selects the variable-length layout |
| insn | input | 32 | Instruction word; for enc_sel=1 the first halfword sits in bits 31:16 |
| base_val | input | XLEN | Value of the base register |
| index_val | input | XLEN | Value of the index register |
| carry_in | input | 1 | Current carry flag, used by the extended rotate |
| hint_valid | output | 1 | One-cycle preload hint strobe |
| hint_write | output | 1 | Intent of the last issued hint: 1 write, 0 read |
| hint_addr | output | XLEN | Target address of the last issued hint |
| unpred_flag | output | 1 | Reserved register combination seen; no hint |
| literal_redirect | output | 1 | Literal-address variant seen; no hint |
| undef_enc | output | 1 | Word does not fit the selected layout; no hint |

## Verification
Every strobe, and any new address or intent, is due at the first rising edge after the accepting cycle. Nothing is due on an idle cycle, and address and intent simply hold. The bench drives each word on a falling edge and compares all six outputs with its reference model at the next falling edge. A cycle with `in_valid` low is checked the same way, against held values and low strobes. After reset release the bench waits past the two-edge synchroniser before it drives a word.

// File: rtl/pld_hint_pkg.sv
package pld_hint_pkg;

  localparam int SH_AMT_W = 6;

  localparam logic [7:0] FIX_OPC_HI = 8'hF7;
  localparam logic [1:0] FIX_OPC_MID = 2'b01;
  localparam logic [9:0] VAR_OPC_HI = 10'b1111100000;
  localparam logic [3:0] REG_ALL_ONES = 4'hF;

  typedef enum logic [2:0] {
    SH_LSL,
    SH_LSR,
    SH_ASR,
    SH_ROR,
    SH_RRX
  } shift_kind_e;

  typedef struct packed {
    logic                fmt_ok;
    logic                literal;
    logic                is_write;
    logic                is_add;
    logic                unpred;
    shift_kind_e         kind;
    logic [SH_AMT_W-1:0] amt;
  } pld_dec_t;

endpackage

// File: rtl/pld_fixed_dec.sv
module pld_fixed_dec
  import pld_hint_pkg::*;
(
  input  logic [31:0] insn,
  output pld_dec_t    dec
);

  logic       u_bit;
  logic       r_bit;
  logic [3:0] rn_f;
  logic [3:0] rm_f;
  logic [4:0] imm5_f;
  logic [1:0] stype_f;
  logic       unused_sbo;

  assign u_bit      = insn[23];
  assign r_bit      = insn[22];
  assign rn_f       = insn[19:16];
  assign imm5_f     = insn[11:7];
  assign stype_f    = insn[6:5];
  assign rm_f       = insn[3:0];
  assign unused_sbo = ^insn[15:12];

  always_comb begin
    dec          = '0;
    dec.fmt_ok   = (insn[31:24] == FIX_OPC_HI) &&
                   (insn[21:20] == FIX_OPC_MID) && !insn[4];
    dec.literal  = 1'b0;
    dec.is_write = !r_bit;
    dec.is_add   = u_bit;
    dec.unpred   = (rm_f == REG_ALL_ONES) ||
                   ((rn_f == REG_ALL_ONES) && !r_bit);
    unique case (stype_f)
      2'b00: begin
        dec.kind = SH_LSL;
        dec.amt  = {1'b0, imm5_f};
      end
      2'b01: begin
        dec.kind = SH_LSR;
        dec.amt  = (imm5_f == 5'd0) ? 6'd32 : {1'b0, imm5_f};
      end
      2'b10: begin
        dec.kind = SH_ASR;
        dec.amt  = (imm5_f == 5'd0) ? 6'd32 : {1'b0, imm5_f};
      end
      default: begin
        if (imm5_f == 5'd0) begin
          dec.kind = SH_RRX;
          dec.amt  = 6'd1;
        end else begin
          dec.kind = SH_ROR;
          dec.amt  = {1'b0, imm5_f};
        end
      end
    endcase
  end

endmodule

// File: rtl/pld_var_dec.sv
module pld_var_dec
  import pld_hint_pkg::*;
(
  input  logic [31:0] insn,
  output pld_dec_t    dec
);

  logic       first_ok;
  logic       second_ok;
  logic       base_is_pc;
  logic [3:0] rm_f;
  logic [1:0] imm2_f;

  assign first_ok   = (insn[31:22] == VAR_OPC_HI) && insn[20];
  assign second_ok  = (insn[15:12] == REG_ALL_ONES) && (insn[11:6] == 6'd0);
  assign base_is_pc = (insn[19:16] == REG_ALL_ONES);
  assign imm2_f     = insn[5:4];
  assign rm_f       = insn[3:0];

  always_comb begin
    dec          = '0;
    dec.literal  = first_ok && base_is_pc;
    dec.fmt_ok   = first_ok && (base_is_pc || second_ok);
    dec.is_write = insn[21];
    dec.is_add   = 1'b1;
    dec.unpred   = (rm_f == REG_ALL_ONES) && !base_is_pc;
    dec.kind     = SH_LSL;
    dec.amt      = {{(SH_AMT_W-2){1'b0}}, imm2_f};
  end

endmodule

// File: rtl/pld_index_shifter.sv
module pld_index_shifter
  import pld_hint_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]        val,
  input  shift_kind_e         kind,
  input  logic [SH_AMT_W-1:0] amt,
  input  logic                carry_in,
  output logic [W-1:0]        shifted
);

  localparam int DW = 2 * W;

  logic [31:0]   amt_w;
  logic [31:0]   rot_w;
  logic          too_far;
  logic [DW-1:0] dbl;
  logic [W-1:0]  asr_res;

  assign amt_w   = 32'(amt);
  assign too_far = (amt_w >= 32'(W));
  assign rot_w   = amt_w % 32'(W);
  assign dbl     = {val, val} >> rot_w;
  assign asr_res = $signed(val) >>> amt_w;

  always_comb begin
    unique case (kind)
      SH_LSL:  shifted = too_far ? '0 : (val << amt_w);
      SH_LSR:  shifted = too_far ? '0 : (val >> amt_w);
      SH_ASR:  shifted = too_far ? {W{val[W-1]}} : asr_res;
      SH_ROR:  shifted = dbl[W-1:0];
      SH_RRX:  shifted = {carry_in, val[W-1:1]};
      default: shifted = '0;
    endcase
  end

endmodule

// File: rtl/pld_addr_gen.sv
module pld_addr_gen #(
  parameter int W            = 32,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  input  logic         is_add,
  output logic [W-1:0] addr
);

  generate
    if (SHARED_ADDER) begin : g_shared
      logic [W-1:0] opnd;
      logic [W-1:0] cin;
      assign opnd = offset ^ {W{!is_add}};
      assign cin  = W'(!is_add);
      assign addr = base + opnd + cin;
    end else begin : g_split
      logic [W-1:0] sum;
      logic [W-1:0] diff;
      assign sum  = base + offset;
      assign diff = base - offset;
      assign addr = is_add ? sum : diff;
    end
  endgenerate

endmodule

// File: rtl/pld_hint_unit.sv
module pld_hint_unit
  import pld_hint_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            enc_sel,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic            carry_in,
  output logic            hint_valid,
  output logic            hint_write,
  output logic [XLEN-1:0] hint_addr,
  output logic            unpred_flag,
  output logic            literal_redirect,
  output logic            undef_enc
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[RST_STAGES-1];

  pld_dec_t dec_fix;
  pld_dec_t dec_var;
  pld_dec_t dec_sel;

  pld_fixed_dec u_fix_dec (.insn(insn), .dec(dec_fix));
  pld_var_dec   u_var_dec (.insn(insn), .dec(dec_var));

  assign dec_sel = enc_sel ? dec_var : dec_fix;

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] addr_calc;

  pld_index_shifter #(.W(XLEN)) u_shift (
    .val      (index_val),
    .kind     (dec_sel.kind),
    .amt      (dec_sel.amt),
    .carry_in (carry_in),
    .shifted  (offset)
  );

  pld_addr_gen #(.W(XLEN), .SHARED_ADDER(SHARED_ADDER)) u_agen (
    .base   (base_val),
    .offset (offset),
    .is_add (dec_sel.is_add),
    .addr   (addr_calc)
  );

  logic            issue_d;
  logic            undef_d;
  logic            redir_d;
  logic            unpred_d;
  logic            write_d;
  logic [XLEN-1:0] addr_d;

  logic            hint_valid_q;
  logic            hint_write_q;
  logic [XLEN-1:0] hint_addr_q;
  logic            unpred_q;
  logic            redir_q;
  logic            undef_q;

  always_comb begin
    undef_d  = in_valid && !dec_sel.fmt_ok;
    redir_d  = in_valid && dec_sel.fmt_ok && dec_sel.literal;
    unpred_d = in_valid && dec_sel.fmt_ok && !dec_sel.literal && dec_sel.unpred;
    issue_d  = in_valid && dec_sel.fmt_ok && !dec_sel.literal && !dec_sel.unpred;
    write_d  = hint_write_q;
    addr_d   = hint_addr_q;
    if (issue_d) begin
      write_d = dec_sel.is_write;
      addr_d  = addr_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hint_valid_q <= 1'b0;
      hint_write_q <= 1'b0;
      hint_addr_q  <= '0;
      unpred_q     <= 1'b0;
      redir_q      <= 1'b0;
      undef_q      <= 1'b0;
    end else begin
      hint_valid_q <= issue_d;
      hint_write_q <= write_d;
      hint_addr_q  <= addr_d;
      unpred_q     <= unpred_d;
      redir_q      <= redir_d;
      undef_q      <= undef_d;
    end
  end

  assign hint_valid       = hint_valid_q;
  assign hint_write       = hint_write_q;
  assign hint_addr        = hint_addr_q;
  assign unpred_flag      = unpred_q;
  assign literal_redirect = redir_q;
  assign undef_enc        = undef_q;

endmodule

// File: rtl/pld_hint_checker.sv
module pld_hint_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            enc_sel,
  input logic [31:0]     insn,
  input logic [XLEN-1:0] base_val,
  input logic [XLEN-1:0] index_val,
  input logic            hint_valid,
  input logic            hint_write,
  input logic [XLEN-1:0] hint_addr,
  input logic            unpred_flag,
  input logic            literal_redirect,
  input logic            undef_enc
);

  a_r10_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(hint_valid || unpred_flag || literal_redirect || undef_enc));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hint_valid, unpred_flag, literal_redirect, undef_enc}));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hint_valid |-> ($stable(hint_addr) && $stable(hint_write)));

  a_r8_redirect_var_only: assert property (@(posedge clk) disable iff (!rst_n)
    literal_redirect |-> $past(enc_sel));

  a_r2_fixed_intent: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && !$past(enc_sel)) |-> (hint_write == !$past(insn[22])));

  a_r6_var_intent: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && $past(enc_sel)) |-> (hint_write == $past(insn[21])));

  a_r7_var_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && $past(enc_sel)) |->
      (hint_addr == $past(base_val) + ($past(index_val) << $past(insn[5:4]))));

  a_r3_fixed_lsl_add: assert property (@(posedge clk) disable iff (!rst_n)
    (hint_valid && !$past(enc_sel) && $past(insn[23]) && ($past(insn[6:5]) == 2'b00)) |->
      (hint_addr == $past(base_val) + ($past(index_val) << $past(insn[11:7]))));

  a_r9_index_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> ($past(insn[3:0]) != 4'hF));

endmodule

bind pld_hint_unit pld_hint_checker #(.XLEN(XLEN)) u_pld_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .enc_sel          (enc_sel),
  .insn             (insn),
  .base_val         (base_val),
  .index_val        (index_val),
  .hint_valid       (hint_valid),
  .hint_write       (hint_write),
  .hint_addr        (hint_addr),
  .unpred_flag      (unpred_flag),
  .literal_redirect (literal_redirect),
  .undef_enc        (undef_enc)
);

// File: tb/pld_hint_unit_tb_top.sv
`timescale 1ns/1ps
module pld_hint_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        enc_sel;
  logic [31:0] insn;
  logic [31:0] base_val;
  logic [31:0] index_val;
  logic        carry_in;
  logic        hint_valid;
  logic        hint_write;
  logic [31:0] hint_addr;
  logic        unpred_flag;
  logic        literal_redirect;
  logic        undef_enc;

  always #10 clk = ~clk;

  pld_hint_unit #(.XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_sel(enc_sel),
    .insn(insn), .base_val(base_val), .index_val(index_val), .carry_in(carry_in),
    .hint_valid(hint_valid), .hint_write(hint_write), .hint_addr(hint_addr),
    .unpred_flag(unpred_flag), .literal_redirect(literal_redirect),
    .undef_enc(undef_enc)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic        e_valid, e_write, e_unpred, e_redir, e_undef;
  logic [31:0] e_addr;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fword(input logic u, input logic r, input logic [3:0] rn,
                                        input logic [4:0] imm5, input logic [1:0] st,
                                        input logic [3:0] rm);
    return {8'hF7, u, r, 2'b01, rn, 4'hF, imm5, st, 1'b0, rm};
  endfunction

  function automatic logic [31:0] vword(input logic w, input logic [3:0] rn,
                                        input logic [1:0] imm2, input logic [3:0] rm);
    return {10'b1111100000, w, 1'b1, rn, 4'hF, 6'd0, imm2, rm};
  endfunction

  task automatic model(input logic v, input logic e, input logic [31:0] i,
                       input logic [31:0] b, input logic [31:0] x, input logic c);
    logic ok, lit, wr, add, up;
    longint unsigned off;
    int n;
    e_valid = 0; e_unpred = 0; e_redir = 0; e_undef = 0;
    if (!v) return;
    lit = 0; add = 1; off = 0;
    if (!e) begin
      ok  = (i[31:24] == 8'hF7) && (i[21:20] == 2'b01) && (i[4] == 1'b0);
      wr  = ~i[22];
      add = i[23];
      up  = (i[3:0] == 4'd15) || ((i[19:16] == 4'd15) && wr);
      n   = int'(i[11:7]);
      case (i[6:5])
        2'b00: off = (longint'(x) << n) & 64'hFFFF_FFFF;
        2'b01: off = (n == 0) ? 0 : (longint'(x) >> n);
        2'b10: begin
          off = longint'($signed(x)) >>> ((n == 0) ? 32 : n);
          off = off & 64'hFFFF_FFFF;
        end
        default: begin
          if (n == 0) off = (longint'(c) << 31) | (longint'(x) >> 1);
          else        off = ((longint'(x) >> n) | (longint'(x) << (32 - n))) & 64'hFFFF_FFFF;
        end
      endcase
    end else begin
      ok  = (i[31:22] == 10'h3E0) && i[20];
      lit = ok && (i[19:16] == 4'd15);
      if (ok && !lit) ok = (i[15:12] == 4'hF) && (i[11:6] == 6'd0);
      wr  = i[21];
      up  = (i[3:0] == 4'd15);
      off = (longint'(x) << i[5:4]) & 64'hFFFF_FFFF;
    end
    if (!ok)      e_undef  = 1;
    else if (lit) e_redir  = 1;
    else if (up)  e_unpred = 1;
    else begin
      e_valid = 1;
      e_write = wr;
      e_addr  = add ? (b + off[31:0]) : (b - off[31:0]);
    end
  endtask

  task automatic step(input logic v, input logic e, input logic [31:0] i,
                      input logic [31:0] b, input logic [31:0] x, input logic c,
                      input string tag);
    in_valid = v; enc_sel = e; insn = i; base_val = b; index_val = x; carry_in = c;
    model(v, e, i, b, x, c);
    @(negedge clk);
    chk(tag, "hint_valid", 32'(hint_valid), 32'(e_valid));
    chk(tag, "hint_write", 32'(hint_write), 32'(e_write));
    chk(tag, "hint_addr", hint_addr, e_addr);
    chk(tag, "unpred_flag", 32'(unpred_flag), 32'(e_unpred));
    chk(tag, "literal_redirect", 32'(literal_redirect), 32'(e_redir));
    chk(tag, "undef_enc", 32'(undef_enc), 32'(e_undef));
  endtask

  initial begin
    rst_n = 0; in_valid = 0; enc_sel = 0; insn = '0;
    base_val = '0; index_val = '0; carry_in = 0;
    e_write = 0; e_addr = '0;
    repeat (3) @(negedge clk);
    chk("R12", "hint_valid", 32'(hint_valid), 0);
    chk("R12", "hint_addr", hint_addr, 0);
    chk("R12", "hint_write", 32'(hint_write), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R12", "undef_enc", 32'(undef_enc), 0);

    // R4 and R3: shift kinds, both directions
    step(1, 0, fword(1, 1, 4'd2, 5'd2, 2'b00, 4'd3), 32'h1000, 32'd3, 0, "R4");
    chk("R3", "lsl add addr", hint_addr, 32'h100C);
    step(1, 0, fword(0, 1, 4'd2, 5'd4, 2'b00, 4'd3), 32'h1000, 32'd1, 0, "R3");
    chk("R3", "sub addr", hint_addr, 32'h0FF0);
    step(1, 0, fword(1, 1, 4'd1, 5'd0, 2'b01, 4'd3), 32'h40, 32'hFFFF_FFFF, 0, "R4");
    chk("R4", "lsr32 addr", hint_addr, 32'h40);
    step(1, 0, fword(1, 1, 4'd1, 5'd0, 2'b10, 4'd3), 32'h40, 32'h8000_0000, 0, "R4");
    chk("R4", "asr32 addr", hint_addr, 32'h3F);
    step(1, 0, fword(1, 1, 4'd1, 5'd8, 2'b11, 4'd3), 32'h0, 32'h0000_00AB, 0, "R4");
    chk("R4", "ror addr", hint_addr, 32'hAB00_0000);
    step(1, 0, fword(1, 1, 4'd1, 5'd0, 2'b11, 4'd3), 32'h0, 32'h0000_0003, 1, "R4");
    chk("R4", "rrx addr", hint_addr, 32'h8000_0001);
    // R2 intent polarity
    step(1, 0, fword(1, 0, 4'd1, 5'd0, 2'b00, 4'd3), 32'h200, 32'h4, 0, "R2");
    chk("R2", "write intent", 32'(hint_write), 1);
    // R1 bad patterns, and should-be-one bits ignored
    step(1, 0, fword(1, 1, 4'd1, 5'd0, 2'b00, 4'd3) ^ 32'h10, 32'h0, 32'h0, 0, "R1");
    step(1, 0, fword(1, 1, 4'd1, 5'd0, 2'b00, 4'd3) ^ 32'h0010_0000, 32'h0, 32'h0, 0, "R1");
    step(1, 0, fword(1, 1, 4'd1, 5'd1, 2'b00, 4'd3) & 32'hFFFF_0FFF, 32'h8, 32'h8, 0, "R1");
    // R9 reserved registers
    step(1, 0, fword(1, 1, 4'd1, 5'd0, 2'b00, 4'd15), 32'h0, 32'h0, 0, "R9");
    step(1, 0, fword(1, 0, 4'd15, 5'd0, 2'b00, 4'd2), 32'h0, 32'h0, 0, "R9");
    step(1, 0, fword(1, 1, 4'd15, 5'd0, 2'b00, 4'd2), 32'h500, 32'h1, 0, "R9");
    step(1, 1, vword(0, 4'd4, 2'd1, 4'd15), 32'h0, 32'h0, 0, "R9");
    // R5 R6 R7 variable form
    step(1, 1, vword(0, 4'd4, 2'd3, 4'd5), 32'h100, 32'h2, 0, "R7");
    chk("R7", "lsl3 addr", hint_addr, 32'h110);
    step(1, 1, vword(1, 4'd4, 2'd0, 4'd5), 32'h100, 32'h2, 0, "R6");
    chk("R6", "write intent", 32'(hint_write), 1);
    step(1, 1, vword(1, 4'd4, 2'd0, 4'd5) ^ 32'h0000_0040, 32'h0, 32'h0, 0, "R5");
    step(1, 1, vword(1, 4'd4, 2'd0, 4'd5) ^ 32'h0010_0000, 32'h0, 32'h0, 0, "R5");
    // R8 literal redirect, lower half arbitrary
    step(1, 1, {vword(0, 4'd15, 2'd0, 4'd0)} ^ 32'h0000_0ABC, 32'h0, 32'h0, 0, "R8");
    step(1, 1, vword(1, 4'd15, 2'd0, 4'd15), 32'h0, 32'h0, 0, "R8");
    // R10 R13 idle cycles hold
    step(0, 1, vword(1, 4'd4, 2'd0, 4'd5), 32'h999, 32'h1, 0, "R10");
    step(0, 0, 32'h0, 32'h0, 32'h0, 0, "R13");
    // R11 mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic e;
      logic [31:0] w;
      e = 1'($urandom_range(0, 1));
      if (e) w = vword(1'($urandom), 4'($urandom), 2'($urandom), 4'($urandom));
      else   w = fword(1'($urandom), 1'($urandom), 4'($urandom), 5'($urandom),
                       2'($urandom), 4'($urandom));
      if ($urandom_range(0, 7) == 0) w = w ^ (32'd1 << $urandom_range(0, 31));
      step(($urandom_range(0, 3) != 0), e, w, $urandom, $urandom, 1'($urandom), "R11");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule